// File: doc/BRIEF.md
# Mode-Select Adder/Subtractor with Carry-Select Groups

This block is a purely combinational N-bit add/subtract unit. One mode input selects between computing A + B + carry_in and A − B − carry_in. In subtract mode, carry_in acts as a borrow-in and carry_out reports a borrow. A signed-overflow flag accompanies the result in both modes. The block has no clock and no state. Every output follows its inputs within the same cycle.

Each bit position is modelled on a bijective one-bit gate. The gate has five inputs (mode, a, b, carry, a constant zero) and five outputs (mode, a ⊕ mode, b, sum, carry), and the same mode line turns it into either a full adder or a full subtractor. No gate output drives more than one load. Where an operand or the mode line is needed twice, a dedicated two-output copy gate makes the copy. The gates are arranged in 4-bit carry-select groups. Every group holds two gate chains, one fed with a constant 0 carry and one with a constant 1. The true carry from the previous group only steers a multiplexer, so carries do not ripple across the full width. All non-result gate outputs of both chains leave the block on a debug port. From that port the inputs of every gate can be recovered.

Top module: `addsub_csel`

## Requirements
- R1: With sub_mode = 0, {carry_out, result} equals op_a + op_b + carry_in computed as an unsigned (WIDTH+1)-bit sum.
- R2: With sub_mode = 1, result equals (op_a − op_b − carry_in) modulo 2^WIDTH.
- R3: With sub_mode = 1, carry_out is a borrow: it is 1 exactly when op_a < op_b + carry_in as unsigned values.
- R4: overflow is 1 exactly when the two's-complement value of op_a ± op_b ± carry_in lies outside the signed WIDTH-bit range. In add mode both op_b and carry_in are added; in subtract mode both are subtracted.
- R5: For bit i, garbage[6i+2:6i] belongs to the carry-0 chain and garbage[6i+5:6i+3] to the carry-1 chain. Within each 3-bit field, bit 2 is sub_mode, bit 1 is op_a[i] XOR sub_mode, and bit 0 is op_b[i].
- R6: A carry or borrow produced in the lowest group propagates through every group boundary. For example, all-ones + 1 gives result 0 with carry_out 1, and 0 − 1 gives all-ones with carry_out 1.
- R7: The block is combinational: outputs reflect new inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand (minuend in subtract mode) |
| op_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| carry_in | input | 1 | Carry-in when adding, borrow-in when subtracting |
| result | output | WIDTH | Sum or difference |
| carry_out | output | 1 | Carry-out when adding, borrow-out when subtracting |
| overflow | output | 1 | Two's-complement overflow of the result |
| garbage | output | 6*WIDTH | Non-result gate outputs of both chains of every bit |

## Verification
The carry-select path and the overflow flag can be exercised by a single input change. The bench provokes this with operands such as 0x7FFFFFFF + 1 and 0x80000000 − 1. In these cases the carry or borrow must pass every group multiplexer, and the overflow flag must rise at the same moment. The bench also drives the full-width cases where carry_out and overflow are both set (0x80000000 + 0x80000000) or where only one is set. Each response is judged against a behavioural model built on wider arithmetic. The flag and the result are sampled together one nanosecond after the inputs settle.

// File: rtl/addsub_csel.sv
module addsub_csel #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  input  logic               sub_mode,
  input  logic               carry_in,
  output logic [WIDTH-1:0]   result,
  output logic               carry_out,
  output logic               overflow,
  output logic [6*WIDTH-1:0] garbage
);
  localparam int NGRP = WIDTH / GROUP;

  // bijective cell: {m, a^m, b, sum, z^carry}
  function automatic logic [4:0] rcell(input logic m, input logic a, input logic b,
                                       input logic c, input logic z);
    logic ax;
    ax = a ^ m;
    return {m, ax, b, c ^ ax ^ b ^ m, z ^ ((ax & b) | (ax & c) | (b & c))};
  endfunction

  function automatic logic [1:0] fcopy(input logic x, input logic z);
    return {x, x ^ z};
  endfunction

  logic [WIDTH-1:0] a0, a1, b0, b1, m0, m1, mlad;
  logic [NGRP:0]    gcy;

  assign mlad[0] = sub_mode;
  assign gcy[0]  = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_copy
    assign {a0[i], a1[i]} = fcopy(op_a[i], 1'b0);
    assign {b0[i], b1[i]} = fcopy(op_b[i], 1'b0);
    if (i == WIDTH - 1) begin : g_last
      assign {m0[i], m1[i]} = fcopy(mlad[i], 1'b0);
    end else begin : g_rung
      logic mx;
      assign {mlad[i+1], mx} = fcopy(mlad[i], 1'b0);
      assign {m0[i], m1[i]}  = fcopy(mx, 1'b0);
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GROUP:0]   c0, c1;
    logic [GROUP-1:0] s0, s1;
    assign c0[0] = 1'b0;
    assign c1[0] = 1'b1;
    for (genvar j = 0; j < GROUP; j++) begin : g_bit
      localparam int K = g * GROUP + j;
      logic [4:0] o0, o1;
      assign o0 = rcell(m0[K], a0[K], b0[K], c0[j], 1'b0);
      assign o1 = rcell(m1[K], a1[K], b1[K], c1[j], 1'b0);
      assign c0[j+1] = o0[0];
      assign c1[j+1] = o1[0];
      assign s0[j]   = o0[1];
      assign s1[j]   = o1[1];
      assign garbage[6*K +: 3]     = o0[4:2];
      assign garbage[6*K + 3 +: 3] = o1[4:2];
    end
    assign result[g*GROUP +: GROUP] = gcy[g] ? s1 : s0;
    assign gcy[g+1] = gcy[g] ? c1[GROUP] : c0[GROUP];
  end

  assign carry_out = gcy[NGRP];

  logic sa, sb, sr;
  assign sa = op_a[WIDTH-1];
  assign sb = op_b[WIDTH-1];
  assign sr = result[WIDTH-1];
  assign overflow = (sr != sa) && (sub_mode ? (sa != sb) : (sa == sb));
endmodule

// File: rtl/addsub_csel_chk.sv
module addsub_csel_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic               sub_mode,
  input logic               carry_in,
  input logic [WIDTH-1:0]   result,
  input logic               carry_out,
  input logic               overflow,
  input logic [6*WIDTH-1:0] garbage
);
  logic [WIDTH:0] uadd, usub, sval;
  always_comb begin
    uadd = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    usub = {1'b0, op_a} - {1'b0, op_b} - {{WIDTH{1'b0}}, carry_in};
    sval = sub_mode ? ({op_a[WIDTH-1], op_a} - {op_b[WIDTH-1], op_b} - {{WIDTH{1'b0}}, carry_in})
                    : ({op_a[WIDTH-1], op_a} + {op_b[WIDTH-1], op_b} + {{WIDTH{1'b0}}, carry_in});
    // R1
    add_sum_chk: assert (sub_mode || {carry_out, result} == uadd);
    // R2
    sub_diff_chk: assert (!sub_mode || result == usub[WIDTH-1:0]);
    // R3
    borrow_out_chk: assert (!sub_mode || carry_out == usub[WIDTH]);
    // R4
    ovf_flag_chk: assert (overflow == (sval[WIDTH] ^ sval[WIDTH-1]));
    for (int i = 0; i < WIDTH; i++) begin
      // R5
      garbage_map_chk: assert (garbage[6*i +: 3] == {sub_mode, op_a[i] ^ sub_mode, op_b[i]}
                           && garbage[6*i+3 +: 3] == garbage[6*i +: 3]);
    end
  end
endmodule

bind addsub_csel addsub_csel_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/addsub_csel_tb.sv
module addsub_csel_tb;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0]   a, b, res;
  logic           m, ci, co, ovf;
  logic [6*W-1:0] gar;
  int checks = 0, errors = 0, cyc = 0;

  addsub_csel #(.WIDTH(W), .GROUP(4)) u_dut (
    .op_a(a), .op_b(b), .sub_mode(m), .carry_in(ci),
    .result(res), .carry_out(co), .overflow(ovf), .garbage(gar));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic md, input logic c);
    @(negedge clk);
    a = x; b = y; m = md; ci = c;
    #1;
  endtask

  task automatic judge();
    logic [W:0] u, s;
    if (!m) begin
      u = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      s = {a[W-1], a} + {b[W-1], b} + {{W{1'b0}}, ci};
      chk("R1 sum", {31'b0, co, res}, {31'b0, u});
    end else begin
      u = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, ci};
      s = {a[W-1], a} - {b[W-1], b} - {{W{1'b0}}, ci};
      chk("R2 diff", {32'b0, res}, {32'b0, u[W-1:0]});
      chk("R3 borrow", {63'b0, co}, {63'b0, u[W]});
    end
    chk("R4 overflow", {63'b0, ovf}, {63'b0, s[W] ^ s[W-1]});
  endtask

  task automatic t_idle();
    apply('0, '0, 1'b0, 1'b0);
    chk("R7 zero state", {30'b0, ovf, co, res}, 64'd0);
  endtask

  task automatic t_directed();
    apply(32'd1234, 32'd4321, 1'b0, 1'b0); judge();
    chk("R1 value", {32'b0, res}, 64'd5555);
    apply(32'd1000, 32'd1, 1'b1, 1'b1);    judge();
    chk("R2 value", {32'b0, res}, 64'd998);
    apply(32'd5, 32'd5, 1'b1, 1'b1);       judge();
    chk("R3 borrow on tie", {63'b0, co}, 64'd1);
    apply(32'd5, 32'd5, 1'b1, 1'b0);       judge();
    chk("R3 no borrow", {63'b0, co}, 64'd0);
  endtask

  task automatic t_boundary();
    apply(32'hFFFF_FFFF, 32'd0, 1'b0, 1'b1); judge();
    chk("R6 full carry", {31'b0, co, res}, 64'h1_0000_0000);
    apply(32'd0, 32'd1, 1'b1, 1'b0);         judge();
    chk("R6 full borrow", {31'b0, co, res}, 64'h1_FFFF_FFFF);
    apply(32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0); judge();
    chk("R4 pos overflow", {63'b0, ovf}, 64'd1);
    apply(32'h8000_0000, 32'd1, 1'b1, 1'b0); judge();
    chk("R4 neg overflow", {63'b0, ovf}, 64'd1);
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0); judge();
    chk("R4 both flags", {62'b0, co, ovf}, 64'd3);
    apply(32'h8000_0000, 32'd0, 1'b1, 1'b1); judge();
    apply(32'h0000_000F, 32'd1, 1'b0, 1'b0); judge();
    chk("R6 group edge", {32'b0, res}, 64'h10);
  endtask

  task automatic t_garbage();
    for (int k = 0; k < 4; k++) begin
      apply($urandom, $urandom, k[0], k[1]);
      for (int i = 0; i < W; i++) begin
        chk("R5 chain0", {61'b0, gar[6*i +: 3]}, {61'b0, m, a[i] ^ m, b[i]});
        chk("R5 chain1", {61'b0, gar[6*i+3 +: 3]}, {61'b0, m, a[i] ^ m, b[i]});
      end
    end
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      apply($urandom, $urandom, k[0], k[1]);
      judge();
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
      finish_up();
    end
  end

  initial begin
    a = '0; b = '0; m = 1'b0; ci = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_directed();
    t_boundary();
    t_garbage();
    t_random();
    finish_up();
  end
endmodule